// File: doc/BRIEF.md
# Subcarrier Realignment Buffer

This block sits after the FFT of an OFDM receiver and corrects a coarse integer subcarrier offset by moving the frequency-domain sample stream to the right. Samples arrive one per clock in index order, with a valid strobe and a marker on the first sample of each 256-sample symbol. A 3-bit shift code selects the correction. The signed offsets to be removed are -12, -8, -4, 0, 4, 8, 12 and 16 subcarriers. A constant bias of 12 is added to them, so the block only ever delays by 0 to 28 positions, always to the right. Code c gives an applied shift of 4*c, and the signed offset it corrects is 4*c - 12.

With the bias in place, a tapped delay memory of 28 entries is enough. An unbiased circular realignment would need close to a whole symbol of storage, because a negative offset moves the first sample to the end of the symbol. The delay is counted in accepted samples, not in clocks. The first S samples of each symbol produce no output, so output position j carries input position j - S. Samples of one symbol never appear in the output of the next.

Top module: `subcarrier_realign`

## Requirements
- R1: After a synchronous reset, out_valid and out_sos are low, applied_shift is 0 and the tap memory is empty.
- R2: On a sample with in_valid and in_sos both high, the block latches shift_code. applied_shift shows 4*code (code 0..7 gives 0..28) from the next cycle on. Changes of shift_code at any other time have no effect until the next start-of-symbol sample.
- R3: For a symbol with shift S, the input at symbol index j is sent out on the clock after the input at index j+S is accepted. This holds for every j from 0 to 255-S, on out_re and out_im.
- R4: The first S accepted samples of a symbol produce no output. out_valid is high only on the clock after an accepted in-symbol sample.
- R5: out_sos is high together with out_valid on the output that carries symbol index 0, and low at all other times.
- R6: A start-of-symbol sample arriving in the middle of a symbol restarts the count with the newly latched code. No sample of the earlier symbol is sent out after it.
- R7: Valid samples that come before the first start-of-symbol after reset, or after the 256th sample of a symbol, produce no output.
- R8: Clocks with in_valid low are not counted as sample slots. They leave the pairing of output and input samples unchanged and produce no output on the next clock.
- R9: With shift code 0, each in-symbol sample is sent out unchanged on the next clock. out_sos then marks the sample that came in with the start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sos | input | 1 | First sample of a symbol (qualified by in_valid) |
| shift_code | input | 3 | Shift selector, applied shift = 4*code |
| in_re | input | W | Real part of input sample |
| in_im | input | W | Imaginary part of input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sos | output | 1 | Output carries symbol index 0 |
| out_re | output | W | Real part of realigned sample |
| out_im | output | W | Imaginary part of realigned sample |
| applied_shift | output | 5 | Shift in force for the current symbol |

## Verification
The bench targets the extreme codes 0 and 7. A wrong tap tap-select or an off-by-one read pointer would show there as data taken one sample early or late, or as a bypass path that adds a clock. It changes shift_code in the middle of a symbol and restarts a symbol in its middle. A design that tracks the code live, or does not clear its fill count, would then mix shifts or leak samples of the old symbol into the new one. It also sends samples before the first marker, samples past index 255, and random gaps in the valid strobe. A design that counts clocks instead of samples, or that runs past the symbol end, would send out extra or misaligned data.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int CODE_W_DEF   = 3;
    localparam int STEP_DEF     = 4;
    localparam int SYM_LEN_DEF  = 256;

    // Per-sample control decision from the sequencer.
    typedef struct packed {
        logic emit;     // output this sample slot
        logic first;    // output carries symbol index 0
        logic bypass;   // zero shift: take the live input
    } slot_ctrl_t;

    function automatic int max_shift(input int code_w, input int step);
        return step * ((1 << code_w) - 1);
    endfunction

    function automatic int bits_for(input int value);
        int n;
        n = 1;
        while ((1 << n) <= value) n++;
        return n;
    endfunction

endpackage

// File: rtl/realign_tap_line.sv
module realign_tap_line #(
    parameter int DW    = 32,
    parameter int DEPTH = 28,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] taps [DEPTH];

    generate
        for (genvar t = 0; t < DEPTH; t++) begin : g_tap
            if (t == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)           taps[t] <= '0;
                    else if (shift_en) taps[t] <= wr_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)           taps[t] <= '0;
                    else if (shift_en) taps[t] <= taps[t-1];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < DEPTH; t++) begin
            if (rd_idx == IDX_W'(t)) rd_data = taps[t];
        end
    end

endmodule

// File: rtl/realign_seq.sv
module realign_seq
    import realign_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int STEP    = 4,
    parameter int SYM_LEN = 256,
    parameter int SH_W    = 5,
    parameter int CNT_W   = 9,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sos,
    input  logic [CODE_W-1:0] shift_code,
    output slot_ctrl_t        ctrl,
    output logic              accept,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [SH_W-1:0]   held_shift
);

    logic              armed_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  idx_q;

    logic              start;
    logic [SH_W-1:0]   cur_shift;
    logic [CNT_W-1:0]  cur_idx;

    always_comb begin
        start     = in_valid && in_sos;
        cur_shift = start ? SH_W'(int'(shift_code) * STEP)
                          : SH_W'(int'(code_q) * STEP);
        cur_idx   = start ? '0 : idx_q;
        accept    = start || (in_valid && armed_q && (idx_q < CNT_W'(SYM_LEN)));
        ctrl.emit   = accept && (cur_idx >= CNT_W'(cur_shift));
        ctrl.first  = accept && (cur_idx == CNT_W'(cur_shift));
        ctrl.bypass = (cur_shift == '0);
        rd_idx      = ctrl.bypass ? '0 : IDX_W'(cur_shift - SH_W'(1));
        held_shift  = SH_W'(int'(code_q) * STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            code_q  <= '0;
            idx_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            code_q  <= shift_code;
            idx_q   <= CNT_W'(1);
        end else if (accept) begin
            idx_q   <= idx_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/subcarrier_realign.sv
module subcarrier_realign
    import realign_pkg::*;
#(
    parameter int W       = SAMPLE_W_DEF,
    parameter int CODE_W  = CODE_W_DEF,
    parameter int STEP    = STEP_DEF,
    parameter int SYM_LEN = SYM_LEN_DEF,
    localparam int MAXSH  = max_shift(CODE_W, STEP),
    localparam int SH_W   = bits_for(MAXSH),
    localparam int CNT_W  = bits_for(SYM_LEN),
    localparam int IDX_W  = bits_for(MAXSH - 1),
    localparam int DW     = 2 * W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sos,
    input  logic [CODE_W-1:0] shift_code,
    input  logic [W-1:0]      in_re,
    input  logic [W-1:0]      in_im,
    output logic              out_valid,
    output logic              out_sos,
    output logic [W-1:0]      out_re,
    output logic [W-1:0]      out_im,
    output logic [SH_W-1:0]   applied_shift
);

    slot_ctrl_t       ctrl;
    logic             accept;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    tap_data;
    logic [DW-1:0]    live_data;
    logic [DW-1:0]    out_data_q;

    assign live_data = {in_re, in_im};

    realign_seq #(
        .CODE_W (CODE_W),
        .STEP   (STEP),
        .SYM_LEN(SYM_LEN),
        .SH_W   (SH_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sos     (in_sos),
        .shift_code (shift_code),
        .ctrl       (ctrl),
        .accept     (accept),
        .rd_idx     (rd_idx),
        .held_shift (applied_shift)
    );

    realign_tap_line #(
        .DW   (DW),
        .DEPTH(MAXSH),
        .IDX_W(IDX_W)
    ) taps_i (
        .clk     (clk),
        .rst     (rst),
        .shift_en(accept),
        .wr_data (live_data),
        .rd_idx  (rd_idx),
        .rd_data (tap_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sos    <= 1'b0;
            out_data_q <= '0;
        end else begin
            out_valid <= ctrl.emit;
            out_sos   <= ctrl.first;
            if (ctrl.emit) out_data_q <= ctrl.bypass ? live_data : tap_data;
        end
    end

    assign out_re = out_data_q[DW-1:W];
    assign out_im = out_data_q[W-1:0];

endmodule

// File: rtl/subcarrier_realign_chk.sv
module subcarrier_realign_chk #(
    parameter int W      = 16,
    parameter int CODE_W = 3,
    parameter int SH_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sos,
    input logic [CODE_W-1:0] shift_code,
    input logic [W-1:0]      in_re,
    input logic              out_valid,
    input logic              out_sos,
    input logic [W-1:0]      out_re,
    input logic [SH_W-1:0]   applied_shift
);

    // R2: shift only moves after a start-of-symbol sample
    assert_shift_held_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_sos) |=> $stable(applied_shift));

    // R2: latched shift equals four times the code
    assert_shift_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sos) |=> (applied_shift == SH_W'(4 * int'($past(shift_code)))));

    // R4 / R8: no output without an accepted sample the clock before
    assert_no_idle_output_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: the start marker only rides on a valid output
    assert_sos_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        out_sos |-> out_valid);

    // R4: with a non-zero code the start sample yields no output
    assert_fill_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sos && shift_code != '0) |=> !out_valid);

    // R9: zero code passes the start sample straight through
    assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sos && shift_code == '0) |=>
            (out_valid && out_sos && out_re == $past(in_re)));

endmodule

bind subcarrier_realign subcarrier_realign_chk #(
    .W     (W),
    .CODE_W(CODE_W),
    .SH_W  (SH_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sos       (in_sos),
    .shift_code   (shift_code),
    .in_re        (in_re),
    .out_valid    (out_valid),
    .out_sos      (out_sos),
    .out_re       (out_re),
    .applied_shift(applied_shift)
);

// File: tb/subcarrier_realign_tb.sv
module subcarrier_realign_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SYM        = 256;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_sos;
    logic [2:0]  shift_code;
    logic [15:0] in_re, in_im;
    logic        out_valid, out_sos;
    logic [15:0] out_re, out_im;
    logic [4:0]  applied_shift;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string ctx = "R1";

    // reference model state
    bit          m_armed = 0;
    int          m_idx = 0;
    int          m_shift = 0;
    logic [15:0] h_re [SYM];
    logic [15:0] h_im [SYM];

    subcarrier_realign dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sos(in_sos),
        .shift_code(shift_code), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sos(out_sos), .out_re(out_re),
        .out_im(out_im), .applied_shift(applied_shift)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [2:0] c);
        return 4 * int'(c);
    endfunction

    // one clock slot: drive at negedge, check at the next negedge
    task automatic step(bit v, bit s, logic [2:0] code, logic [15:0] re, logic [15:0] im);
        bit ev, es;
        logic [15:0] er, ei;
        ev = 0; es = 0; er = 0; ei = 0;
        in_valid = v; in_sos = s; shift_code = code; in_re = re; in_im = im;
        if (v && s) begin
            m_armed = 1; m_idx = 0; m_shift = shift_of(code);
        end
        if (v && m_armed && m_idx < SYM) begin
            h_re[m_idx] = re; h_im[m_idx] = im;
            if (m_idx >= m_shift) begin
                ev = 1; es = (m_idx == m_shift);
                er = h_re[m_idx - m_shift]; ei = h_im[m_idx - m_shift];
            end
            m_idx++;
        end
        @(negedge clk);
        check("R4", int'(out_valid), int'(ev));
        check("R5", int'(out_sos), int'(es));
        check("R2", int'(applied_shift), m_shift);
        if (ev) begin
            check("R3", int'(out_re), int'(er));
            check("R3", int'(out_im), int'(ei));
        end
    endtask

    task automatic idle();
        step(0, 0, 3'($urandom), 16'($urandom), 16'($urandom));
    endtask

    // a symbol of n samples; gap_pct chance of an idle slot before each;
    // shift_code is scrambled on every non-start sample
    task automatic symbol(logic [2:0] code, int n, int gap_pct);
        for (int k = 0; k < n; k++) begin
            while (int'($urandom % 100) < gap_pct) idle();
            step(1, k == 0, (k == 0) ? code : 3'($urandom),
                 16'($urandom), 16'($urandom));
        end
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        rst = 1; in_valid = 0; in_sos = 0; shift_code = 0; in_re = 0; in_im = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        ctx = "R1";
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sos), 0);
        check("R1", int'(applied_shift), 0);

        ctx = "R7";
        for (int k = 0; k < 5; k++) step(1, 0, 3'd0, 16'(k + 1), 16'(k + 7));

        ctx = "R9";
        symbol(3'd0, SYM, 0);

        ctx = "R7";
        symbol(3'd7, SYM + 4, 0);
        idle();

        ctx = "R6";
        symbol(3'd3, 100, 0);
        symbol(3'd5, SYM, 0);

        ctx = "R8";
        for (int s = 0; s < 5; s++) symbol(3'($urandom), SYM, 25);
        symbol(3'd1, SYM, 40);
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule